// File: doc/BRIEF.md
# Interlaced 525-Line Digital Video Timing Generator and Byte Serializer

This block produces a free-running, byte-serial component video stream for an external video encoder. Three counters set the pace. A two-bit phase counter advances on every clock. A horizontal counter steps once per four clocks, because each horizontal count carries one 32-bit pixel-pair word. A vertical counter steps each time the horizontal counter wraps.

The horizontal and vertical counts are decoded into region codes. From those codes, every word is built as one of three kinds: a timing reference word (end or start of active video), a blanking word, or a pixel word. A pixel word is fetched from an external source by line number and pixel-pair column, and each of its bytes is clipped to the legal video range. The chosen word is captured in a holding register once every four clocks. Its four bytes are then sent one per clock on a 10-bit output, with two zero bits appended below each byte.

The stream carries no valid or ready pins. Video timing cannot be paused, so the encoder takes one sample on every clock and there is no back-pressure. The pixel source sees plain request pins. It must present the requested word before the end of the four-clock span in which the request is shown. A `start` level stands in for "encoder configured". While `start` is low the block is held at the first sample of the frame.

Top module: `vid_timing_serializer`

## Requirements
- R1: While `start` is high, the phase counter counts 0,1,2,3,0 on every clock. When the phase is 3, the horizontal count advances modulo H_TOTAL (430 by default). When the horizontal count wraps to 0, the vertical count advances modulo V_TOTAL (525 by default).
- R2: The horizontal count decodes to a region code: 0 is EAV (code 0); H_SAV_POS (68) is SAV (code 2); H_SAV_POS+1..H_ACT_LAST (69..428) is active (code 3); every other count, including 429, is blanking (code 1).
- R3: The vertical count decodes to a region code: 0..2 and 265..271 give code 0; 3..8 and 263..264 give code 1; 9..262 give code 2 (active, first field); 272..524 give code 3 (active, second field).
- R4: In the EAV and SAV regions the four bytes sent are 0xFF, 0x00, 0x00, XY, in that order. XY = {1, F, V, H, V^H, F^H, F^V, F^V^H}, where H is 1 for EAV and 0 for SAV, and (F,V) is (1,1), (0,1), (0,0) or (1,0) for vertical codes 0, 1, 2 and 3. These bytes are not clipped.
- R5: A pixel word is sent only when the horizontal code is 3 and the vertical code is 2 or 3. Every other region sends the blanking bytes 0x80, 0x10, 0x80, 0x10, in that order.
- R6: `pix_req` is high exactly when the current count is an active pixel position. `pix_col` is then the horizontal count minus (H_SAV_POS+1). `pix_line` is 2*(vcount-9) for vertical code 2 (even source lines) and 2*(vcount-272)+1 for vertical code 3 (odd source lines). The request stays stable for the whole four-clock span.
- R7: Each byte of a pixel word is clipped independently: values below 0x10 become 0x10, and values above 0xF0 become 0xF0.
- R8: On the clock edge where the phase is 3, the holding register captures the word for the current counts. During the next four clocks, `vid_out` carries bits 7:0, then 15:8, then 23:16, then 31:24, each as {byte, 2'b00}.
- R9: While `start` is low (and after reset), all counters and the holding register are cleared and `vid_out` is 0. Raising `start` begins the frame at counts 0/0/0, so the first word reaches `vid_out` four clocks later. Dropping `start` in the middle of a frame returns the block to this state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run enable; low holds the block at the start of a frame |
| pix_word | input | 32 | Pixel-pair word for the current request; bits 7:0 are sent first |
| pix_req | output | 1 | Current position needs a pixel word |
| pix_line | output | $clog2(V_TOTAL)+1 | Requested source line |
| pix_col | output | $clog2(H_TOTAL) | Requested pixel-pair column |
| vid_out | output | 10 | Serial sample: {byte, 2'b00} |

## Verification
The bench goes after these corners:
- **Region edges.** The counts around 0/1, 67/68/69 and 428/429, and the vertical edges 2/3 and 8/9. A design with an off-by-one edge sends a timing or blanking word where pixels belong, or pixels into blanking.
- **XY byte.** Every vertical code is combined with both EAV and SAV. A wrong F, V or protection bit changes the fourth byte of the reference word.
- **Clipping.** The pixel pattern reaches values below 0x10 and above 0xF0. A missing or off-by-one clip shows as raw bytes on the output.
- **Line parity per field.** A field with the wrong parity requests the wrong source lines.
- **Byte order and latency.** A swapped byte order or a load one clock early moves every sample.
- **Restart.** Dropping `start` in the middle of a frame must return the output to the first-frame sequence. A design that leaves the holding register or a counter uncleared starts out of step.

// File: rtl/vts_pkg.sv
package vts_pkg;

  typedef enum logic [1:0] {
    HR_EAV    = 2'd0,
    HR_BLANK  = 2'd1,
    HR_SAV    = 2'd2,
    HR_ACTIVE = 2'd3
  } hreg_e;

  typedef enum logic [1:0] {
    VR_F2_BLANK  = 2'd0,
    VR_F1_BLANK  = 2'd1,
    VR_F1_ACTIVE = 2'd2,
    VR_F2_ACTIVE = 2'd3
  } vreg_e;

  localparam logic [7:0] CLIP_LO = 8'h10;
  localparam logic [7:0] CLIP_HI = 8'hF0;

  function automatic logic [7:0] clip8(input logic [7:0] b);
    if (b < CLIP_LO)      return CLIP_LO;
    else if (b > CLIP_HI) return CLIP_HI;
    else                  return b;
  endfunction

  // Fourth byte of a timing reference word, with protection bits.
  function automatic logic [7:0] ref_xy(input hreg_e h, input vreg_e v);
    logic hb, fb, vb;
    hb = (h == HR_EAV);
    case (v)
      VR_F2_BLANK:  begin fb = 1'b1; vb = 1'b1; end
      VR_F1_BLANK:  begin fb = 1'b0; vb = 1'b1; end
      VR_F1_ACTIVE: begin fb = 1'b0; vb = 1'b0; end
      default:      begin fb = 1'b1; vb = 1'b0; end
    endcase
    return {1'b1, fb, vb, hb, vb ^ hb, fb ^ hb, fb ^ vb, fb ^ vb ^ hb};
  endfunction

endpackage

// File: rtl/vts_counters.sv
module vts_counters #(
  parameter int H_TOTAL = 430,
  parameter int V_TOTAL = 525,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [1:0]    phase,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      hcnt  <= '0;
      vcnt  <= '0;
    end else if (!run) begin
      phase <= '0;
      hcnt  <= '0;
      vcnt  <= '0;
    end else begin
      phase <= phase + 2'd1;
      if (phase == 2'd3) begin
        if (hcnt == H_LAST) begin
          hcnt <= '0;
          vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vts_region.sv
module vts_region
  import vts_pkg::*;
#(
  parameter int H_TOTAL        = 430,
  parameter int H_SAV_POS      = 68,
  parameter int H_ACT_LAST     = 428,
  parameter int V_TOTAL        = 525,
  parameter int V_BLK_A_LAST   = 2,
  parameter int V_BLK_B_LAST   = 8,
  parameter int V_ACT_ODD_LAST = 262,
  parameter int V_BLK_C_LAST   = 264,
  parameter int V_BLK_D_LAST   = 271,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  output hreg_e         hreg,
  output vreg_e         vreg,
  output logic          pix_req,
  output logic [VW:0]   pix_line,
  output logic [HW-1:0] pix_col
);
  localparam logic [HW-1:0] H_SAV  = HW'(H_SAV_POS);
  localparam logic [HW-1:0] H_ACT0 = HW'(H_SAV_POS + 1);
  localparam logic [HW-1:0] H_ACTL = HW'(H_ACT_LAST);
  localparam logic [VW-1:0] V_A    = VW'(V_BLK_A_LAST);
  localparam logic [VW-1:0] V_B    = VW'(V_BLK_B_LAST);
  localparam logic [VW-1:0] V_ODD  = VW'(V_ACT_ODD_LAST);
  localparam logic [VW-1:0] V_C    = VW'(V_BLK_C_LAST);
  localparam logic [VW-1:0] V_D    = VW'(V_BLK_D_LAST);
  localparam logic [VW-1:0] V_F1_0 = VW'(V_BLK_B_LAST + 1);
  localparam logic [VW-1:0] V_F2_0 = VW'(V_BLK_D_LAST + 1);

  always_comb begin
    if (hcnt == '0)                          hreg = HR_EAV;
    else if (hcnt == H_SAV)                  hreg = HR_SAV;
    else if (hcnt >= H_ACT0 && hcnt <= H_ACTL) hreg = HR_ACTIVE;
    else                                     hreg = HR_BLANK;
  end

  always_comb begin
    if (vcnt <= V_A)        vreg = VR_F2_BLANK;
    else if (vcnt <= V_B)   vreg = VR_F1_BLANK;
    else if (vcnt <= V_ODD) vreg = VR_F1_ACTIVE;
    else if (vcnt <= V_C)   vreg = VR_F1_BLANK;
    else if (vcnt <= V_D)   vreg = VR_F2_BLANK;
    else                    vreg = VR_F2_ACTIVE;
  end

  always_comb begin
    pix_req  = 1'b0;
    pix_line = '0;
    pix_col  = '0;
    if (hreg == HR_ACTIVE &&
        (vreg == VR_F1_ACTIVE || vreg == VR_F2_ACTIVE)) begin
      pix_req = 1'b1;
      pix_col = hcnt - H_ACT0;
      if (vreg == VR_F1_ACTIVE) pix_line = {vcnt - V_F1_0, 1'b0};
      else                      pix_line = {vcnt - V_F2_0, 1'b1};
    end
  end
endmodule

// File: rtl/vts_word_sel.sv
module vts_word_sel
  import vts_pkg::*;
(
  input  hreg_e        hreg,
  input  vreg_e        vreg,
  input  logic [31:0]  pix_word,
  output logic [31:0]  word_out
);
  logic [31:0] clipped;

  for (genvar i = 0; i < 4; i++) begin : g_clip
    assign clipped[8*i +: 8] = clip8(pix_word[8*i +: 8]);
  end

  always_comb begin
    if (hreg == HR_EAV || hreg == HR_SAV)
      word_out = {ref_xy(hreg, vreg), 8'h00, 8'h00, 8'hFF};
    else if (hreg == HR_ACTIVE &&
             (vreg == VR_F1_ACTIVE || vreg == VR_F2_ACTIVE))
      word_out = clipped;
    else
      word_out = {8'h10, 8'h80, 8'h10, 8'h80};
  end
endmodule

// File: rtl/vid_timing_serializer.sv
module vid_timing_serializer
  import vts_pkg::*;
#(
  parameter int H_TOTAL        = 430,
  parameter int H_SAV_POS      = 68,
  parameter int H_ACT_LAST     = 428,
  parameter int V_TOTAL        = 525,
  parameter int V_BLK_A_LAST   = 2,
  parameter int V_BLK_B_LAST   = 8,
  parameter int V_ACT_ODD_LAST = 262,
  parameter int V_BLK_C_LAST   = 264,
  parameter int V_BLK_D_LAST   = 271,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   pix_word,
  output logic          pix_req,
  output logic [VW:0]   pix_line,
  output logic [HW-1:0] pix_col,
  output logic [9:0]    vid_out
);
  logic [1:0]    phase;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  hreg_e         hreg;
  vreg_e         vreg;
  logic [31:0]   next_word;
  logic [31:0]   hold;

  vts_counters #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(start),
    .phase(phase), .hcnt(hcnt), .vcnt(vcnt)
  );

  vts_region #(
    .H_TOTAL(H_TOTAL), .H_SAV_POS(H_SAV_POS), .H_ACT_LAST(H_ACT_LAST),
    .V_TOTAL(V_TOTAL), .V_BLK_A_LAST(V_BLK_A_LAST),
    .V_BLK_B_LAST(V_BLK_B_LAST), .V_ACT_ODD_LAST(V_ACT_ODD_LAST),
    .V_BLK_C_LAST(V_BLK_C_LAST), .V_BLK_D_LAST(V_BLK_D_LAST)
  ) u_region (
    .hcnt(hcnt), .vcnt(vcnt), .hreg(hreg), .vreg(vreg),
    .pix_req(pix_req), .pix_line(pix_line), .pix_col(pix_col)
  );

  vts_word_sel u_sel (
    .hreg(hreg), .vreg(vreg), .pix_word(pix_word), .word_out(next_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold <= '0;
    else if (!start)         hold <= '0;
    else if (phase == 2'd3)  hold <= next_word;
  end

  assign vid_out = {hold[{phase, 3'b000} +: 8], 2'b00};
endmodule

// File: rtl/vts_checker.sv
module vts_checker #(
  parameter int H_TOTAL = 430,
  parameter int V_TOTAL = 525,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    phase,
  input logic [HW-1:0] hcnt,
  input logic [VW-1:0] vcnt,
  input logic          pix_req,
  input logic [VW:0]   pix_line,
  input logic [HW-1:0] pix_col,
  input logic [9:0]    vid_out
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (phase == $past(phase) + 2'd1));

  a_r1_h_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (start && phase == 2'd3 && hcnt == H_LAST) |=> (hcnt == '0));

  a_r1_v_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (start && phase == 2'd3 && hcnt == H_LAST && vcnt == V_LAST)
      |=> (vcnt == '0));

  a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (phase == 2'd0 && hcnt == '0 && vcnt == '0 && vid_out == '0));

  a_r6_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (start && $past(start) && phase != 2'd0)
      |-> ($stable(pix_req) && $stable(pix_line) && $stable(pix_col)));
endmodule

bind vid_timing_serializer vts_checker #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .phase(phase), .hcnt(hcnt),
  .vcnt(vcnt), .pix_req(pix_req), .pix_line(pix_line), .pix_col(pix_col),
  .vid_out(vid_out)
);

// File: tb/vid_timing_serializer_test.sv
module vid_timing_serializer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #4 clk = ~clk;

  // small configuration: 12 counts per line, 20 lines
  logic        s_req;
  logic [5:0]  s_line;
  logic [3:0]  s_col;
  logic [9:0]  s_out;
  logic [31:0] s_word;
  // default configuration
  logic        f_req;
  logic [10:0] f_line;
  logic [8:0]  f_col;
  logic [9:0]  f_out;
  logic [31:0] f_word;

  function automatic logic [31:0] pat(int line, int col);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) w[8*i +: 8] = 8'((line * 37 + col * 11 + i * 67 + 5) & 255);
    return w;
  endfunction

  assign s_word = pat(int'(s_line), int'(s_col));
  assign f_word = pat(int'(f_line), int'(f_col));

  vid_timing_serializer #(
    .H_TOTAL(12), .H_SAV_POS(5), .H_ACT_LAST(10), .V_TOTAL(20),
    .V_BLK_A_LAST(1), .V_BLK_B_LAST(3), .V_ACT_ODD_LAST(8),
    .V_BLK_C_LAST(9), .V_BLK_D_LAST(11)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_word(s_word),
    .pix_req(s_req), .pix_line(s_line), .pix_col(s_col), .vid_out(s_out)
  );

  vid_timing_serializer uut_full (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_word(f_word),
    .pix_req(f_req), .pix_line(f_line), .pix_col(f_col), .vid_out(f_out)
  );

  typedef struct {
    int ht, hs, hl, vt, va, vb, vo, vc, vd;
  } cfg_t;

  function automatic int hcode(cfg_t c, int hc);
    if (hc == 0) return 0;
    if (hc == c.hs) return 2;
    if (hc > c.hs && hc <= c.hl) return 3;
    return 1;
  endfunction

  function automatic int vcode(cfg_t c, int vc);
    if (vc <= c.va) return 0;
    if (vc <= c.vb) return 1;
    if (vc <= c.vo) return 2;
    if (vc <= c.vc) return 1;
    if (vc <= c.vd) return 0;
    return 3;
  endfunction

  function automatic int exp_line(cfg_t c, int vc);
    if (vcode(c, vc) == 2) return 2 * (vc - c.vb - 1);
    return 2 * (vc - c.vd - 1) + 1;
  endfunction

  function automatic logic [7:0] clipb(logic [7:0] b);
    if (b < 8'h10) return 8'h10;
    if (b > 8'hF0) return 8'hF0;
    return b;
  endfunction

  // expected sample after t clock edges with start high
  function automatic logic [9:0] exp_out(cfg_t c, int t);
    int m, b, hc, vc, hd, vd, ln, cl;
    logic [7:0] by;
    logic hh, ff, vv;
    logic [31:0] w;
    if (t < 4) return 10'd0;
    m  = (t - 4) / 4;
    b  = t % 4;
    hc = m % c.ht;
    vc = (m / c.ht) % c.vt;
    hd = hcode(c, hc);
    vd = vcode(c, vc);
    if (hd == 3 && vd >= 2) begin
      ln = exp_line(c, vc);
      cl = hc - c.hs - 1;
      w  = pat(ln, cl);
      by = clipb(w[8*b +: 8]);
    end else if (hd == 0 || hd == 2) begin
      hh = (hd == 0);
      ff = (vd == 0 || vd == 3);
      vv = (vd == 0 || vd == 1);
      case (b)
        0: by = 8'hFF;
        1, 2: by = 8'h00;
        default: by = {1'b1, ff, vv, hh, vv ^ hh, ff ^ hh, ff ^ vv, ff ^ vv ^ hh};
      endcase
    end else begin
      by = (b % 2 == 0) ? 8'h80 : 8'h10;
    end
    return {by, 2'b00};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R1 R2 R3 R4 R5 R7 R8: the serial sample; R6: the pixel request
  task automatic check_at(cfg_t c, int t, logic [9:0] out, logic req,
                          int line, int col, string tag);
    int mc, hc, vc, ereq;
    chk("R8", {tag, " vid_out (R2 R3 R4 R5 R7)"}, int'(out), int'(exp_out(c, t)));
    mc = t / 4;
    hc = mc % c.ht;
    vc = (mc / c.ht) % c.vt;
    ereq = (hcode(c, hc) == 3 && vcode(c, vc) >= 2) ? 1 : 0;
    chk("R6", {tag, " pix_req"}, int'(req), ereq);
    if (ereq == 1) begin
      chk("R6", {tag, " pix_line"}, line, exp_line(c, vc));
      chk("R6", {tag, " pix_col"}, col, hc - c.hs - 1);
    end
  endtask

  cfg_t cs = '{12, 5, 10, 20, 1, 3, 8, 9, 11};
  cfg_t cf = '{430, 68, 428, 525, 2, 8, 262, 264, 271};

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state and idle hold
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9", "idle vid_out", int'(s_out), 0);
      chk("R9", "idle pix_req", int'(s_req), 0);
      chk("R9", "idle full vid_out", int'(f_out), 0);
    end
    start = 1'b1;
    // R1: whole small frames repeat; full config covers first 11 lines
    for (int t = 1; t <= 19000; t++) begin
      @(negedge clk);
      check_at(cs, t, s_out, s_req, int'(s_line), int'(s_col), "small");
      check_at(cf, t, f_out, f_req, int'(f_line), int'(f_col), "full");
    end
    // R9: drop start mid-frame
    start = 1'b0;
    @(negedge clk);
    chk("R9", "stopped vid_out", int'(s_out), 0);
    chk("R9", "stopped full vid_out", int'(f_out), 0);
    @(negedge clk);
    chk("R9", "stopped vid_out second clock", int'(s_out), 0);
    start = 1'b1;
    for (int t = 1; t <= 1200; t++) begin
      @(negedge clk);
      check_at(cs, t, s_out, s_req, int'(s_line), int'(s_col), "R9 restart small");
      check_at(cf, t, f_out, f_req, int'(f_line), int'(f_col), "R9 restart full");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule